// File: doc/BRIEF.md
# Nibble-Serial Packet Buffer Port

This block sits between a host that can only move four bits at a time over a parallel-port style link and a byte-wide packet buffer RAM on the device. When the host writes, the block builds each byte from two nibble transfers and stores it at a buffer pointer that advances on its own. When the host reads, it issues a read command naming the buffer address register. The block fetches the byte at the pointer and places the requested half on four status lines. The pointer advances after the upper half has been handed out.

Two write strobe styles are supported. In the fast style, bit 4 of each data-port value marks which half it carries. In the backup style, the nibble is parked on the data lines and a separate control-port select bit says which half it is. The backup style is for hosts whose data lines arrive with skew. The pointer can be reloaded from the host side at any time, and it wraps at the end of the buffer. The host must discard the first word it reads at the start of a received packet. Because of this the pointer is free-running and makes no special case of that word.

Top module: `nsp_buffer_port`

## Requirements
- R1: While reset is held and after it is released, `ram_we` is 0, `ram_raddr` is 0 and `host_status` is 0 until the host acts.
- R2: With `strobe_mode`=0, a data-port write whose bits 7:5 are 000 and whose bit 4 is 0 captures bits 3:0 as the pending low nibble. A later such write replaces the earlier one.
- R3: With `strobe_mode`=0, a data-port write whose bits 7:5 are 000 and whose bit 4 is 1, while a low nibble is pending, raises `ram_we` for exactly one cycle on the next cycle. `ram_wdata` is {bits 3:0, pending low} and `ram_waddr` is the pointer. The pending nibble is cleared.
- R4: A high-nibble strobe with no pending low nibble causes no RAM write and leaves the pointer unchanged.
- R5: The pointer (`ram_raddr`) rises by one after each completed byte. A 16-bit word sent as four nibbles, least significant first with bit 4 set to 0,1,0,1, lands as two bytes, low byte at the lower address.
- R6: With `strobe_mode`=1, data-port writes with bits 7:5 = 000 only park bits 3:0 and never write RAM. A control strobe with `hc_sel`=1 takes the parked nibble as the low half. A control strobe with `hc_sel`=0 completes the byte as in R3 when a low half is pending.
- R7: A data-port write of 0xCE (read command, register 14, bit 4 clear) shows the low nibble of the byte at the pointer on `host_status` bits 6:3 on the next cycle, and the pointer is unchanged. A write of 0xDE shows the high nibble and advances the pointer by one. Status bits 7 and 2:0 are always 0.
- R8: `addr_load` sets the pointer to `addr_val` on the next cycle and discards any pending low nibble. Any host strobe in the same cycle is ignored.
- R9: The pointer wraps from 2047 to 0, both on writes and on high-nibble reads.
- R10: Other data-port values (bits 7:5 not 000 and not a read command for register 14) change neither the pending nibble, the pointer, the RAM nor the status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strobe_mode | input | 1 | 0 fast style, 1 backup style |
| hd_wr | input | 1 | One-cycle pulse: host wrote the data port |
| hd_data | input | 8 | Synchronized data-port value |
| hc_wr | input | 1 | One-cycle pulse: host wrote the control port |
| hc_sel | input | 1 | Control select bit (1 low-half strobe, 0 high-half strobe) |
| addr_load | input | 1 | Reload the buffer pointer |
| addr_val | input | 11 | Pointer reload value |
| ram_we | output | 1 | Buffer RAM write enable |
| ram_waddr | output | 11 | Buffer RAM write address |
| ram_wdata | output | 8 | Buffer RAM write data |
| ram_raddr | output | 11 | Buffer RAM read address, equal to the pointer |
| ram_rdata | input | 8 | Buffer RAM read data, combinational from `ram_raddr` |
| host_status | output | 8 | Status lines, nibble on bits 6:3 |

## Verification
The hardest case to reach is the pointer crossing the end of the buffer. Walking 2048 bytes through nibble strobes would take most of the run. Instead, the stimulus reloads the pointer to 2047 and then completes one byte. It repeats this with a high-nibble read. A second case is the collision of a reload with a host strobe and a pending low nibble. The stimulus leaves a low half pending, then raises `addr_load` in the same cycle as a high-half strobe. A further high-half strobe then shows that nothing is written.

// File: rtl/nsp_pkg.sv
package nsp_pkg;

  localparam int unsigned NIB_W = 4;

  typedef enum logic [2:0] {
    EV_NONE = 3'd0,
    EV_LO   = 3'd1,
    EV_HI   = 3'd2,
    EV_RLO  = 3'd3,
    EV_RHI  = 3'd4
  } nsp_ev_e;

  typedef struct packed {
    nsp_ev_e          kind;
    logic [NIB_W-1:0] nib;
  } nsp_evt_t;

  // data-port value carrying a nibble: top three bits clear
  function automatic logic is_nib_val(input logic [7:0] v);
    return v[7:5] == 3'b000;
  endfunction

  // read command aimed at the buffer address register
  function automatic logic is_rd_cmd(input logic [7:0] v, input logic [3:0] idx);
    return (v[7:6] == 2'b11) && !v[5] && (v[3:0] == idx);
  endfunction

endpackage

// File: rtl/nsp_rst_sync.sv
module nsp_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sh_q[STAGES-1];
endmodule

// File: rtl/nsp_decode.sv
module nsp_decode
  import nsp_pkg::*;
#(
  parameter logic [3:0] BUF_REG_IDX = 4'd14
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     strobe_mode,
  input  logic     hd_wr,
  input  logic [7:0] hd_data,
  input  logic     hc_wr,
  input  logic     hc_sel,
  input  logic     addr_load,
  output nsp_evt_t evt
);
  logic [NIB_W-1:0] park_q, park_d;
  logic             park_en;
  logic             nib_hit, rd_hit;

  assign nib_hit = hd_wr && is_nib_val(hd_data);
  assign rd_hit  = hd_wr && is_rd_cmd(hd_data, BUF_REG_IDX);

  // parked nibble for the backup strobe style
  always_comb begin
    park_en = strobe_mode && nib_hit;
    park_d  = hd_data[NIB_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       park_q <= '0;
    else if (park_en) park_q <= park_d;
  end

  // one event per cycle; reload wins, then control strobe, then data port
  always_comb begin
    evt.kind = EV_NONE;
    evt.nib  = '0;
    if (addr_load) begin
      evt.kind = EV_NONE;
    end else if (strobe_mode && hc_wr) begin
      evt.kind = hc_sel ? EV_LO : EV_HI;
      evt.nib  = park_q;
    end else if (rd_hit) begin
      evt.kind = hd_data[4] ? EV_RHI : EV_RLO;
    end else if (!strobe_mode && nib_hit) begin
      evt.kind = hd_data[4] ? EV_HI : EV_LO;
      evt.nib  = hd_data[NIB_W-1:0];
    end
  end
endmodule

// File: rtl/nsp_assemble.sv
module nsp_assemble
  import nsp_pkg::*;
#(
  parameter int unsigned AW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  nsp_evt_t      evt,
  input  logic          addr_load,
  input  logic [AW-1:0] ptr,
  output logic          byte_done,
  output logic          pend,
  output logic          ram_we,
  output logic [AW-1:0] ram_waddr,
  output logic [7:0]    ram_wdata
);
  logic             pend_q, pend_d;
  logic [NIB_W-1:0] lo_q, lo_d;
  logic             lo_en;
  logic             we_q, we_d;
  logic [AW-1:0]    wa_q, wa_d;
  logic [7:0]       wd_q, wd_d;

  always_comb begin
    byte_done = (evt.kind == EV_HI) && pend_q;
    lo_en     = (evt.kind == EV_LO);
    lo_d      = evt.nib;
    pend_d    = pend_q;
    if (addr_load)      pend_d = 1'b0;
    else if (lo_en)     pend_d = 1'b1;
    else if (byte_done) pend_d = 1'b0;
    we_d = byte_done;
    wa_d = byte_done ? ptr : wa_q;
    wd_d = byte_done ? {evt.nib, lo_q} : wd_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      lo_q   <= '0;
      we_q   <= 1'b0;
      wa_q   <= '0;
      wd_q   <= '0;
    end else begin
      pend_q <= pend_d;
      if (lo_en) lo_q <= lo_d;
      we_q   <= we_d;
      wa_q   <= wa_d;
      wd_q   <= wd_d;
    end
  end

  assign pend      = pend_q;
  assign ram_we    = we_q;
  assign ram_waddr = wa_q;
  assign ram_wdata = wd_q;
endmodule

// File: rtl/nsp_pointer.sv
module nsp_pointer #(
  parameter int unsigned AW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] load_val,
  input  logic          step,
  output logic [AW-1:0] ptr
);
  logic [AW-1:0] ptr_q, ptr_d;
  logic          ptr_en;

  // natural AW-bit wrap gives the buffer-size modulus
  always_comb begin
    ptr_en = load || step;
    ptr_d  = load ? load_val : ptr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ptr_q <= '0;
    else if (ptr_en) ptr_q <= ptr_d;
  end

  assign ptr = ptr_q;
endmodule

// File: rtl/nsp_readout.sv
module nsp_readout
  import nsp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  nsp_evt_t   evt,
  input  logic [7:0] rdata,
  output logic [7:0] host_status
);
  logic [NIB_W-1:0] nib_q, nib_d;
  logic             nib_en;

  always_comb begin
    nib_en = (evt.kind == EV_RLO) || (evt.kind == EV_RHI);
    nib_d  = (evt.kind == EV_RHI) ? rdata[7:4] : rdata[3:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      nib_q <= '0;
    else if (nib_en) nib_q <= nib_d;
  end

  // nibble rides on status bits 6:3
  assign host_status = {1'b0, nib_q, 3'b000};
endmodule

// File: rtl/nsp_buffer_port.sv
module nsp_buffer_port
  import nsp_pkg::*;
#(
  parameter int unsigned AW          = 11,
  parameter logic [3:0]  BUF_REG_IDX = 4'd14
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          strobe_mode,
  input  logic          hd_wr,
  input  logic [7:0]    hd_data,
  input  logic          hc_wr,
  input  logic          hc_sel,
  input  logic          addr_load,
  input  logic [AW-1:0] addr_val,
  output logic          ram_we,
  output logic [AW-1:0] ram_waddr,
  output logic [7:0]    ram_wdata,
  output logic [AW-1:0] ram_raddr,
  input  logic [7:0]    ram_rdata,
  output logic [7:0]    host_status
);
  logic          rst_q_n;
  nsp_evt_t      evt;
  logic          byte_done, pend_low, step;
  logic [AW-1:0] ptr;
  nsp_ev_e       ev_kind;

  nsp_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_q_n)
  );

  nsp_decode #(.BUF_REG_IDX(BUF_REG_IDX)) u_dec (
    .clk(clk), .rst_n(rst_q_n), .strobe_mode(strobe_mode),
    .hd_wr(hd_wr), .hd_data(hd_data), .hc_wr(hc_wr), .hc_sel(hc_sel),
    .addr_load(addr_load), .evt(evt)
  );

  nsp_assemble #(.AW(AW)) u_asm (
    .clk(clk), .rst_n(rst_q_n), .evt(evt), .addr_load(addr_load), .ptr(ptr),
    .byte_done(byte_done), .pend(pend_low), .ram_we(ram_we),
    .ram_waddr(ram_waddr), .ram_wdata(ram_wdata)
  );

  assign step    = byte_done || (evt.kind == EV_RHI);
  assign ev_kind = evt.kind;

  nsp_pointer #(.AW(AW)) u_ptr (
    .clk(clk), .rst_n(rst_q_n), .load(addr_load), .load_val(addr_val),
    .step(step), .ptr(ptr)
  );

  nsp_readout u_rd (
    .clk(clk), .rst_n(rst_q_n), .evt(evt), .rdata(ram_rdata),
    .host_status(host_status)
  );

  assign ram_raddr = ptr;
endmodule

// File: rtl/nsp_checker.sv
module nsp_checker
  import nsp_pkg::*;
#(
  parameter int unsigned AW = 11
) (
  input logic          clk,
  input logic          rst_n,
  input logic          addr_load,
  input logic [AW-1:0] addr_val,
  input logic          ram_we,
  input logic [AW-1:0] ram_waddr,
  input logic [AW-1:0] ram_raddr,
  input logic [7:0]    host_status,
  input nsp_ev_e       ev_kind,
  input logic          pending
);
  logic [AW-1:0] waddr_next;
  assign waddr_next = ram_waddr + 1'b1;

  a_r3_we_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |=> !ram_we);

  a_r3_hi_completes: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_kind == EV_HI && pending) |=> ram_we);

  a_r4_lone_hi: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_kind == EV_HI && !pending) |=> !ram_we);

  // R5 and R9: pointer sits one past the byte being written (modulo buffer)
  a_r5_ptr_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> ram_raddr == waddr_next);

  a_r7_low_read_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_kind == EV_RLO) |=> ram_raddr == $past(ram_raddr));

  a_r7_status_frame: assert property (@(posedge clk) disable iff (!rst_n)
    (host_status[7] == 1'b0) && (host_status[2:0] == 3'b000));

  a_r8_reload: assert property (@(posedge clk) disable iff (!rst_n)
    addr_load |=> (ram_raddr == $past(addr_val)) && !ram_we);
endmodule

bind nsp_buffer_port nsp_checker #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_q_n), .addr_load(addr_load), .addr_val(addr_val),
  .ram_we(ram_we), .ram_waddr(ram_waddr), .ram_raddr(ram_raddr),
  .host_status(host_status), .ev_kind(ev_kind), .pending(pend_low)
);

// File: tb/sim_nsp_buffer_port.sv
module sim_nsp_buffer_port;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 11;
  localparam int DEPTH = 1 << AW;

  logic clk, rst_n, strobe_mode, hd_wr, hc_wr, hc_sel, addr_load;
  logic [7:0] hd_data, ram_wdata, ram_rdata, host_status;
  logic [AW-1:0] addr_val, ram_waddr, ram_raddr;
  logic ram_we;

  int errors = 0;
  int checks = 0;

  logic [7:0] mem [DEPTH];
  logic [7:0] exp_mem [DEPTH];

  // reference model state
  int m_ptr, m_lo, m_park, m_nib;
  bit m_pend, m_we;
  int m_waddr, m_wdata;

  nsp_buffer_port #(.AW(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .strobe_mode(strobe_mode), .hd_wr(hd_wr),
    .hd_data(hd_data), .hc_wr(hc_wr), .hc_sel(hc_sel), .addr_load(addr_load),
    .addr_val(addr_val), .ram_we(ram_we), .ram_waddr(ram_waddr),
    .ram_wdata(ram_wdata), .ram_raddr(ram_raddr), .ram_rdata(ram_rdata),
    .host_status(host_status)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) if (ram_we) mem[ram_waddr] <= ram_wdata;
  assign ram_rdata = mem[ram_raddr];

  function automatic int pat(int i);
    return (i * 7 + 3) & 8'hFF;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // behavioural model, updated on each edge with the inputs held since the last falling edge
  always @(posedge clk) begin
    m_we = 1'b0;
    if (!rst_n) begin
      m_ptr = 0; m_lo = 0; m_park = 0; m_nib = 0; m_pend = 0;
    end else begin
      if (addr_load) begin
        m_ptr = addr_val; m_pend = 0;
      end else if (strobe_mode && hc_wr) begin
        if (hc_sel) begin m_lo = m_park; m_pend = 1; end
        else if (m_pend) begin
          m_we = 1; m_waddr = m_ptr; m_wdata = (m_park << 4) | m_lo;
          exp_mem[m_ptr] = m_wdata[7:0]; m_ptr = (m_ptr + 1) % DEPTH; m_pend = 0;
        end
      end else if (hd_wr && hd_data[7:5] == 3'b110 && hd_data[3:0] == 4'd14) begin
        if (hd_data[4]) begin m_nib = exp_mem[m_ptr] >> 4; m_ptr = (m_ptr + 1) % DEPTH; end
        else m_nib = exp_mem[m_ptr] & 15;
      end else if (hd_wr && !strobe_mode && hd_data[7:5] == 3'b000) begin
        if (!hd_data[4]) begin m_lo = hd_data[3:0]; m_pend = 1; end
        else if (m_pend) begin
          m_we = 1; m_waddr = m_ptr; m_wdata = (hd_data[3:0] << 4) | m_lo;
          exp_mem[m_ptr] = m_wdata[7:0]; m_ptr = (m_ptr + 1) % DEPTH; m_pend = 0;
        end
      end
      if (hd_wr && strobe_mode && hd_data[7:5] == 3'b000) m_park = hd_data[3:0];
    end
  end

  // per-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      check(ram_we == m_we, "R3 model we", ram_we, m_we);
      if (m_we) begin
        check(ram_waddr == m_waddr, "R5 model waddr", ram_waddr, m_waddr);
        check(ram_wdata == m_wdata, "R3 model wdata", ram_wdata, m_wdata);
      end
      check(ram_raddr == m_ptr, "R5 model ptr", ram_raddr, m_ptr);
      check(host_status == (m_nib << 3), "R7 model status", host_status, m_nib << 3);
    end
  end

  task automatic dwr(input logic [7:0] v);
    @(negedge clk); hd_wr = 1'b1; hd_data = v;
    @(negedge clk); hd_wr = 1'b0;
  endtask

  task automatic cwr(input logic sel);
    @(negedge clk); hc_wr = 1'b1; hc_sel = sel;
    @(negedge clk); hc_wr = 1'b0;
  endtask

  task automatic load(input int a);
    @(negedge clk); addr_load = 1'b1; addr_val = a[AW-1:0];
    @(negedge clk); addr_load = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=0x0 expected=0x1");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) begin mem[i] = pat(i); exp_mem[i] = pat(i); end
    rst_n = 1'b0; strobe_mode = 1'b0; hd_wr = 1'b0; hd_data = '0;
    hc_wr = 1'b0; hc_sel = 1'b0; addr_load = 1'b0; addr_val = '0;
    idle(4);
    check(ram_we == 1'b0 && ram_raddr == 0 && host_status == 0, "R1 in reset",
          {ram_we, ram_raddr, host_status}, 0);
    rst_n = 1'b1;
    idle(4);
    check(ram_we == 1'b0 && ram_raddr == 0 && host_status == 0, "R1 after release",
          {ram_we, ram_raddr, host_status}, 0);

    load(16'h010);
    check(ram_raddr == 11'h010, "R8 load value", ram_raddr, 16'h010);

    dwr(8'h0C); dwr(8'h13); idle(1);
    check(mem[16'h010] == 8'h3C, "R3 byte assembled", mem[16'h010], 8'h3C);
    check(ram_raddr == 11'h011, "R5 pointer step", ram_raddr, 16'h011);

    dwr(8'h01); dwr(8'h07); dwr(8'h12); idle(1);
    check(mem[16'h011] == 8'h27, "R2 low nibble replaced", mem[16'h011], 8'h27);

    dwr(8'h1F); idle(1);
    check(ram_raddr == 11'h012, "R4 lone high ptr", ram_raddr, 16'h012);
    check(mem[16'h012] == pat(16'h012), "R4 lone high mem", mem[16'h012], pat(16'h012));

    dwr(8'h0F); dwr(8'h1E); dwr(8'h0E); dwr(8'h1B); idle(1);
    check(mem[16'h012] == 8'hEF, "R5 word low byte", mem[16'h012], 8'hEF);
    check(mem[16'h013] == 8'hBE, "R5 word high byte", mem[16'h013], 8'hBE);

    dwr(8'h04); dwr(8'hE0); dwr(8'h4A); dwr(8'hCD); dwr(8'h2B);
    check(host_status == 8'h00 && ram_raddr == 11'h014, "R10 foreign values",
          {host_status, ram_raddr}, 16'h014);
    dwr(8'h19); idle(1);
    check(mem[16'h014] == 8'h94, "R10 pending kept", mem[16'h014], 8'h94);

    strobe_mode = 1'b1;
    dwr(8'h06); dwr(8'h1A); idle(1);
    check(ram_raddr == 11'h015, "R6 data port alone", ram_raddr, 16'h015);
    cwr(1'b0); idle(1);
    check(ram_raddr == 11'h015, "R6 high strobe without low", ram_raddr, 16'h015);
    dwr(8'h06); cwr(1'b1); dwr(8'h0D); cwr(1'b0); idle(1);
    check(mem[16'h015] == 8'hD6, "R6 backup byte", mem[16'h015], 8'hD6);
    check(ram_raddr == 11'h016, "R6 backup ptr", ram_raddr, 16'h016);
    strobe_mode = 1'b0;

    load(16'h012);
    dwr(8'hCE);
    check(host_status == 8'h78 && ram_raddr == 11'h012, "R7 low read",
          {host_status, ram_raddr}, 16'h7812);
    dwr(8'hDE);
    check(host_status == 8'h70 && ram_raddr == 11'h013, "R7 high read",
          {host_status, ram_raddr}, 16'h7013);

    load(16'h7FF);
    dwr(8'h01); dwr(8'h12); idle(1);
    check(mem[16'h7FF] == 8'h21, "R9 last byte", mem[16'h7FF], 8'h21);
    check(ram_raddr == 0, "R9 write wrap", ram_raddr, 0);
    load(16'h7FF);
    dwr(8'hDE);
    check(ram_raddr == 0 && host_status == 8'h10, "R9 read wrap",
          {host_status, ram_raddr}, 16'h1000);

    load(16'h020);
    dwr(8'h05);
    @(negedge clk); addr_load = 1'b1; addr_val = 11'h030; hd_wr = 1'b1; hd_data = 8'h1F;
    @(negedge clk); addr_load = 1'b0; hd_wr = 1'b0;
    check(ram_raddr == 11'h030 && ram_we == 1'b0, "R8 load beats strobe",
          {ram_we, ram_raddr}, 16'h030);
    dwr(8'h13); idle(1);
    check(ram_raddr == 11'h030 && mem[16'h030] == pat(16'h030), "R8 pending dropped",
          mem[16'h030], pat(16'h030));

    idle(2);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule